// File: doc/BRIEF.md
# Software-Controlled Set/Reset Latch

This block is a single set/reset storage element that a processor steers through one 8-bit control register. Software enables the latch, chooses a clock-divider code, decides which of the two latch outputs reaches the outside, and can set or reset the latch by writing one-shot command bits. These command bits stay high for one instruction period (four system clocks) and then drop by themselves. A software write can only raise them.

A programmable divider derives a strobe, one system clock wide, from the system clock. Its period is 4 clocks for code 0 and doubles with each code step, up to 512 clocks. Two side inputs decide whether the strobe sets the latch, resets it, both or neither, so the latch can act as a periodic flag or a simple pulse stretcher. The true and complementary outputs are registered. Each is gated by its own enable and by the latch enable.

Top module: `srlatch_periph`

## Requirements
- R1: The control register reads back as {bit 7 latch enable, bits 6:4 divider code, bit 3 true-output enable, bit 2 complement-output enable, bit 1 set command, bit 0 reset command}. A write with `wr_en` high loads bits 7:2 on that clock edge.
- R2: After synchronous reset, all eight register bits read 0 and both outputs are 0.
- R3: Divider code c produces a strobe, one clock wide, every 4·2^c system clocks.
- R4: Writing 1 to bit 1 (or bit 0) raises the set (or reset) command for exactly 4 clocks. During that time it sets (or resets) the latch. Afterwards the bit reads 0.
- R5: Writing 0 to a command bit neither clears a command in progress nor starts one.
- R6: With `div_set_en` high a strobe sets the latch. With `div_rst_en` high a strobe resets it. With both low, strobes leave the latch unchanged.
- R7: One clock after the register changes, `q_out` equals enable AND true-output enable AND latch state, and `nq_out` equals enable AND complement-output enable AND NOT latch state.
- R8: When set and reset sources act in the same cycle, the latch resets.
- R9: While the latch enable is 0, the latch is held at 0 and both outputs drive 0. A set command issued while disabled is lost.
- R10: Every register write restarts the divider count, so the first strobe after a write comes one full period after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register contents |
| div_set_en | input | 1 | Divider strobe acts as a set source |
| div_rst_en | input | 1 | Divider strobe acts as a reset source |
| q_out | output | 1 | Gated latch output |
| nq_out | output | 1 | Gated complementary latch output |

## Verification
The bench sweeps all eight divider codes. For each code it checks that the first strobe after a write lands exactly one period later and that the next strobe lands one period after that. A divider that does not restart on a write, or that is off by one in its period, misses these edges. It overlaps a zero write with a running command, which catches a design that lets software clear the command bit. It also issues set and reset together, which catches a design where set wins. Finally, it issues a set command while the latch is disabled, which catches a design that lets the latch keep state when it is off.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int SEL_W     = 3;
  localparam int BASE_LOG  = 2;
  localparam int PULSE_LEN = 4;
  localparam int CTRL_W    = 5 + SEL_W;

  localparam int BIT_EN   = CTRL_W - 1;
  localparam int BIT_QOE  = 3;
  localparam int BIT_NQOE = 2;
  localparam int BIT_SET  = 1;
  localparam int BIT_CLR  = 0;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             qoe;
    logic             nqoe;
  } ctrl_t;
endpackage

// File: rtl/srl_divider.sv
module srl_divider #(
  parameter int SEL_W    = 3,
  parameter int BASE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] last;

  always_comb begin
    period = (CNT_W+1)'(1) << (32'(sel) + BASE_LOG);
    last   = CNT_W'(period - 1'b1);
    strobe = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (strobe)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/srl_pulse.sv
module srl_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic pulse
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      cnt   <= '0;
    end else if (pulse) begin
      if (cnt == LAST) begin
        pulse <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (arm) begin
      pulse <= 1'b1;
      cnt   <= '0;
    end
  end

  assert_pulse_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |-> ($past(cnt) == LAST));
  assert_no_sw_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (pulse && cnt != LAST) |=> pulse);
endmodule

// File: rtl/srl_core.sv
module srl_core (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic qoe,
  input  logic nqoe,
  input  logic set_in,
  input  logic clr_in,
  output logic q_out,
  output logic nq_out
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst || !en)  q <= 1'b0;
    else if (clr_in) q <= 1'b0;
    else if (set_in) q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out  <= 1'b0;
      nq_out <= 1'b0;
    end else begin
      q_out  <= en & qoe & q;
      nq_out <= en & nqoe & ~q;
    end
  end

  assert_reset_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (en && clr_in) |=> !q);
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !q);
  assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!q_out && !nq_out));
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(q_out && nq_out));
endmodule

// File: rtl/srlatch_periph.sv
module srlatch_periph
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              div_set_en,
  input  logic              div_rst_en,
  output logic              q_out,
  output logic              nq_out
);
  ctrl_t      ctrl;
  logic [1:0] cmd;
  logic       strobe;
  logic       set_in;
  logic       clr_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.en   <= wr_data[BIT_EN];
      ctrl.sel  <= wr_data[BIT_EN-1 -: SEL_W];
      ctrl.qoe  <= wr_data[BIT_QOE];
      ctrl.nqoe <= wr_data[BIT_NQOE];
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cmd
    srl_pulse #(.LEN(PULSE_LEN)) i_pulse (
      .clk   (clk),
      .rst   (rst),
      .arm   (wr_en & wr_data[i]),
      .pulse (cmd[i])
    );
  end

  srl_divider #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) i_div (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_en),
    .sel     (ctrl.sel),
    .strobe  (strobe)
  );

  always_comb begin
    set_in  = cmd[BIT_SET] | (div_set_en & strobe);
    clr_in  = cmd[BIT_CLR] | (div_rst_en & strobe);
    rd_data = {ctrl, cmd[BIT_SET], cmd[BIT_CLR]};
  end

  srl_core i_core (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl.en),
    .qoe    (ctrl.qoe),
    .nqoe   (ctrl.nqoe),
    .set_in (set_in),
    .clr_in (clr_in),
    .q_out  (q_out),
    .nq_out (nq_out)
  );

  assert_write_load_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[CTRL_W-1:2] == $past(wr_data[CTRL_W-1:2])));
endmodule

// File: tb/test_srlatch_periph.sv
module test_srlatch_periph;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       div_set_en = 1'b0;
  logic       div_rst_en = 1'b0;
  logic       q_out, nq_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  srlatch_periph i_srlatch_periph (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .div_set_en(div_set_en), .div_rst_en(div_rst_en), .q_out(q_out), .nq_out(nq_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R2 reset reg", rd_data, 8'h00);
    check("R2 reset q", {7'd0, q_out}, 8'h00);
    check("R2 reset nq", {7'd0, nq_out}, 8'h00);

    wr(8'h8C);
    check("R1 readback", rd_data, 8'h8C);
    step(1);
    check("R7 nq on", {7'd0, nq_out}, 8'h01);
    check("R7 q off", {7'd0, q_out}, 8'h00);

    wr(8'h8E);
    check("R4 set cmd reads 1", rd_data, 8'h8E);
    step(2);
    check("R4 set q", {7'd0, q_out}, 8'h01);
    check("R4 set nq", {7'd0, nq_out}, 8'h00);
    step(2);
    check("R4 set cmd self-clear", rd_data, 8'h8C);

    wr(8'h8D);
    wr(8'h8C);
    check("R5 zero write keeps cmd", rd_data, 8'h8D);
    step(1);
    check("R4 reset q", {7'd0, q_out}, 8'h00);
    check("R4 reset nq", {7'd0, nq_out}, 8'h01);
    step(2);
    check("R5 cmd ends on time", rd_data, 8'h8C);

    wr(8'h8E); step(5);
    wr(8'h8C); step(5);
    check("R5 zero write no reset", {7'd0, q_out}, 8'h01);

    wr(8'h8F); step(2);
    check("R8 reset wins q", {7'd0, q_out}, 8'h00);
    check("R8 reset wins nq", {7'd0, nq_out}, 8'h01);
    step(3);
    check("R4 both cmds clear", rd_data, 8'h8C);

    wr(8'h8E); step(5);
    wr(8'h84); step(1);
    check("R7 qoe off q", {7'd0, q_out}, 8'h00);
    check("R7 qoe off nq", {7'd0, nq_out}, 8'h00);
    wr(8'h88); step(1);
    check("R7 qoe on q", {7'd0, q_out}, 8'h01);
    check("R7 nqoe off nq", {7'd0, nq_out}, 8'h00);

    wr(8'h0C); step(1);
    check("R9 disabled q", {7'd0, q_out}, 8'h00);
    check("R9 disabled nq", {7'd0, nq_out}, 8'h00);
    wr(8'h0E); step(5);
    check("R9 cmd clears while off", rd_data, 8'h0C);
    wr(8'h8C); step(1);
    check("R9 latch held low q", {7'd0, q_out}, 8'h00);
    check("R9 latch held low nq", {7'd0, nq_out}, 8'h01);

    for (int s = 0; s < 8; s++) begin
      int p;
      logic [7:0] cfg;
      p = 4 << s;
      cfg = {1'b1, 3'(s), 4'b1100};
      wr(cfg | 8'h01); step(5);
      wr(cfg);
      div_set_en = 1'b1;
      step(p);
      check($sformatf("R10 no early strobe code %0d", s), {7'd0, q_out}, 8'h00);
      step(1);
      check($sformatf("R3 first strobe code %0d", s), {7'd0, q_out}, 8'h01);
      div_set_en = 1'b0;
      div_rst_en = 1'b1;
      step(p - 1);
      check($sformatf("R6 before reset strobe code %0d", s), {7'd0, q_out}, 8'h01);
      step(1);
      check($sformatf("R3 R6 period code %0d", s), {7'd0, q_out}, 8'h00);
      div_rst_en = 1'b0;
    end

    wr(8'h8E); step(600);
    check("R6 no source keeps q", {7'd0, q_out}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule